// File: doc/BRIEF.md
# Wired Interrupt to Message Bridge

This block turns the activity on a wide bank of wired interrupt lines into posted 64-bit memory-write messages for a parent interrupt controller. Each line has its own configuration word giving an enable bit, an edge/level choice, a group number and a 24-bit message number. When a configured line fires, the block writes that message number to the "set" doorbell address of the line's group. In level mode, a line in the level-capable group also reports its deassertion by writing the same number to a separate "clear" doorbell address. The edge-only group has just a set doorbell and is always edge-triggered, whatever its edge bit says.

Software programs the doorbell addresses and the configuration words through a simple register port with combinational read data. Events are latched as pending flags, one per line. A two-state machine serves them one at a time, lowest line number first, through a valid/ready write channel. In state `ST_SCAN` the machine looks for a pending flag. On the transition *found*, it captures the address and data of the winning flag, clears that flag and moves to `ST_OFFER`. In `ST_OFFER` it presents the message. On the transition *accepted* (valid and ready both high) it returns to `ST_SCAN`.

Top module: `wire_msg_bridge`

## Requirements
- R1: After reset, every doorbell and configuration register reads as zero and `msg_valid` is low.
- R2: A register read returns the last value written. Doorbells sit at 0x10/0x14 (level group set, low/high), 0x18/0x1C (level group clear, low/high) and 0x50/0x54 (edge group set, low/high). The configuration word of line n sits at 0x100 + 4*n for n in 0..N_IRQ-1. A configuration offset for n >= N_IRQ (such as 0x43C) ignores writes and reads as zero.
- R3: In a configuration word, bit 24 is the enable, bit 28 selects edge mode, bits 31:29 hold the group (0 = level-capable, 1 = edge-only) and bits 23:0 hold the payload. An enabled line in edge mode sends one message on each 0-to-1 transition and nothing on a 1-to-0 transition. That message goes to its group's set doorbell {high,low}, with data {8'h00, payload}.
- R4: An enabled group-0 line in level mode sends a message to the group-0 set doorbell when it rises, and a message to the group-0 clear doorbell when it falls.
- R5: A group-1 line is edge-triggered even with bit 28 clear, and it never sends anything on a falling transition.
- R6: A line with bit 24 clear, or with a group number of 2 or more, sends no message.
- R7: Any write to a line's configuration word discards that line's not-yet-captured event. After a zero is written, the line sends nothing more.
- R8: When several lines are pending, they are sent in ascending line order.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Synchronised wired interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| msg_valid | output | 1 | Message write is offered |
| msg_ready | input | 1 | Parent accepts the message |
| msg_addr | output | 64 | Doorbell address of the message |
| msg_data | output | 32 | Message data, upper 8 bits zero |

## Verification
The hardest case to reach is a configuration write that lands on a line whose event is pending but not yet captured. This only happens while the output stage is occupied. The stimulus holds `msg_ready` low, fires two lines in the same cycle so that the lower one is captured and the higher one waits, and then writes zero to the waiting line before releasing ready. The same stall, with three lines fired together, also exercises the ascending order and lets the bench check that the held message stays stable cycle after cycle.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
    typedef enum logic {ST_SCAN, ST_OFFER} wmb_state_e;

    localparam int PAY_W    = 24;
    localparam int EN_BIT   = 24;
    localparam int EDGE_BIT = 28;
    localparam int GRP_LSB  = 29;
    localparam int GRP_W    = 3;
    localparam int CFG_BASE = 'h100;

    localparam logic [GRP_W-1:0] GRP_LEVEL = 3'd0;
    localparam logic [GRP_W-1:0] GRP_EDGE  = 3'd1;

    // doorbell slots: 0..3 at 0x10..0x1C, 4..7 at 0x50..0x5C
    localparam int DB_SET0_LO = 0;
    localparam int DB_SET0_HI = 1;
    localparam int DB_CLR0_LO = 2;
    localparam int DB_CLR0_HI = 3;
    localparam int DB_SET1_LO = 4;
    localparam int DB_SET1_HI = 5;
    localparam int DB_SLOTS   = 8;
endpackage

// File: rtl/wmb_regs.sv
module wmb_regs
    import wmb_pkg::*;
#(
    parameter int N_IRQ = 207,
    parameter int AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [N_IRQ-1:0]  cfg_hit,
    output logic [N_IRQ-1:0]  cfg_en,
    output logic [N_IRQ-1:0]  cfg_edge,
    output logic [GRP_W-1:0]  cfg_grp [N_IRQ],
    output logic [PAY_W-1:0]  cfg_pay [N_IRQ],
    output logic [63:0]       set0_addr,
    output logic [63:0]       clr0_addr,
    output logic [63:0]       set1_addr
);
    localparam int IW = AW - 2;

    logic [31:0]   cfg_q [N_IRQ];
    logic [31:0]   db_q  [DB_SLOTS];
    logic [AW-1:0] cfg_off;
    logic [IW-1:0] cfg_idx;
    logic          cfg_ok;
    logic          db_ok;
    logic [2:0]    db_idx;

    always_comb begin
        cfg_off = addr - AW'(CFG_BASE);
        cfg_idx = cfg_off[AW-1:2];
        cfg_ok  = (addr >= AW'(CFG_BASE)) && (addr[1:0] == 2'b00)
                  && (int'(cfg_idx) < N_IRQ);
        db_ok   = (addr[1:0] == 2'b00) &&
                  ((addr[AW-1:4] == (AW-4)'(1)) || (addr[AW-1:4] == (AW-4)'(5)));
        db_idx  = {addr[6], addr[3:2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DB_SLOTS; k++) db_q[k] <= '0;
        end else if (we && db_ok) begin
            db_q[db_idx] <= wdata;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_IRQ; gi++) begin : g_cfg
            assign cfg_hit[gi] = we && cfg_ok && (int'(cfg_idx) == gi);
            always_ff @(posedge clk) begin
                if (!rst_n)           cfg_q[gi] <= '0;
                else if (cfg_hit[gi]) cfg_q[gi] <= wdata;
            end
            assign cfg_en[gi]   = cfg_q[gi][EN_BIT];
            assign cfg_edge[gi] = cfg_q[gi][EDGE_BIT];
            assign cfg_grp[gi]  = cfg_q[gi][GRP_LSB +: GRP_W];
            assign cfg_pay[gi]  = cfg_q[gi][PAY_W-1:0];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (db_ok)       rdata = db_q[db_idx];
        else if (cfg_ok) rdata = cfg_q[cfg_idx];
    end

    assign set0_addr = {db_q[DB_SET0_HI], db_q[DB_SET0_LO]};
    assign clr0_addr = {db_q[DB_CLR0_HI], db_q[DB_CLR0_LO]};
    assign set1_addr = {db_q[DB_SET1_HI], db_q[DB_SET1_LO]};

    // R2: a write that matches no register never strobes a configuration word
    assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || !cfg_ok) |-> (cfg_hit == '0));
endmodule

// File: rtl/wmb_track.sv
module wmb_track
    import wmb_pkg::*;
#(
    parameter int N_IRQ = 207
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [N_IRQ-1:0]  cfg_hit,
    input  logic [N_IRQ-1:0]  cfg_en,
    input  logic [N_IRQ-1:0]  cfg_edge,
    input  logic [GRP_W-1:0]  cfg_grp [N_IRQ],
    input  logic [N_IRQ-1:0]  take,
    output logic [N_IRQ-1:0]  pend,
    output logic [N_IRQ-1:0]  kind_clr
);
    logic [N_IRQ-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_IRQ; gi++) begin : g_line
            logic lvl_mode, edg_mode, rise, fall;
            assign lvl_mode = cfg_en[gi] && (cfg_grp[gi] == GRP_LEVEL) && !cfg_edge[gi];
            assign edg_mode = cfg_en[gi] && (((cfg_grp[gi] == GRP_LEVEL) && cfg_edge[gi])
                                             || (cfg_grp[gi] == GRP_EDGE));
            assign rise = irq_in[gi] && !prev_q[gi];
            assign fall = !irq_in[gi] && prev_q[gi];

            always_ff @(posedge clk) begin
                if (!rst_n || cfg_hit[gi]) begin
                    pend[gi]     <= 1'b0;
                    kind_clr[gi] <= 1'b0;
                end else if (lvl_mode && (rise || fall)) begin
                    pend[gi]     <= 1'b1;
                    kind_clr[gi] <= fall;
                end else if (edg_mode && rise) begin
                    pend[gi]     <= 1'b1;
                    kind_clr[gi] <= 1'b0;
                end else if (take[gi]) begin
                    pend[gi]     <= 1'b0;
                end
            end

            // R7: a configuration write leaves no event pending for the line
            assert_wipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_hit[gi] |=> !pend[gi]);
            // R5: an edge-only line never holds a clear event
            assert_no_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_en[gi] && cfg_grp[gi] == GRP_EDGE && !cfg_hit[gi]) |=> !kind_clr[gi]);
        end
    endgenerate
endmodule

// File: rtl/wmb_pick.sv
module wmb_pick #(
    parameter int N_IRQ = 207,
    parameter int IW    = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  pend,
    output logic              any,
    output logic [IW-1:0]     idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

    // R8: the chosen line is really pending
    assert_pick_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> pend[idx]);
endmodule

// File: rtl/wire_msg_bridge.sv
module wire_msg_bridge
    import wmb_pkg::*;
#(
    parameter int N_IRQ = 207
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data
);
    localparam int IW = $clog2(N_IRQ);

    logic [N_IRQ-1:0] cfg_hit, cfg_en, cfg_edge, pend, kind_clr, take;
    logic [GRP_W-1:0] cfg_grp [N_IRQ];
    logic [PAY_W-1:0] cfg_pay [N_IRQ];
    logic [63:0]      set0_addr, clr0_addr, set1_addr;
    logic             any;
    logic [IW-1:0]    idx;
    wmb_state_e       state_q, state_d;
    logic [63:0]      addr_q;
    logic [31:0]      data_q;

    wmb_regs #(.N_IRQ(N_IRQ), .AW(12)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .cfg_hit(cfg_hit), .cfg_en(cfg_en), .cfg_edge(cfg_edge),
        .cfg_grp(cfg_grp), .cfg_pay(cfg_pay), .set0_addr(set0_addr),
        .clr0_addr(clr0_addr), .set1_addr(set1_addr)
    );

    wmb_track #(.N_IRQ(N_IRQ)) u_track (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_hit(cfg_hit),
        .cfg_en(cfg_en), .cfg_edge(cfg_edge), .cfg_grp(cfg_grp), .take(take),
        .pend(pend), .kind_clr(kind_clr)
    );

    wmb_pick #(.N_IRQ(N_IRQ), .IW(IW)) u_pick (
        .clk(clk), .rst_n(rst_n), .pend(pend), .any(any), .idx(idx)
    );

    // next state and capture strobe
    always_comb begin
        state_d = state_q;
        take    = '0;
        unique case (state_q)
            ST_SCAN: if (any) begin
                state_d = ST_OFFER;
                take    = N_IRQ'(1) << idx;
            end
            ST_OFFER: if (msg_ready) state_d = ST_SCAN;
            default: state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    // message capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == ST_SCAN && any) begin
            if (kind_clr[idx])                  addr_q <= clr0_addr;
            else if (cfg_grp[idx] == GRP_LEVEL) addr_q <= set0_addr;
            else                                addr_q <= set1_addr;
            data_q <= {8'h00, cfg_pay[idx]};
        end
    end

    assign msg_valid = (state_q == ST_OFFER);
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;

    // R9: offered message stays put until accepted
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    // R3: upper data byte is always zero on the channel
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:24] == 8'h00));
    // R8: at most one line captured per cycle
    assert_one_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
endmodule

// File: tb/tb_wire_msg_bridge.sv
module tb_wire_msg_bridge;
    localparam int N = 207;
    localparam logic [63:0] SET0 = 64'h00000001_F0000040;
    localparam logic [63:0] CLR0 = 64'h00000001_F0000048;
    localparam logic [63:0] SET1 = 64'h00000002_E0000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0;
    int errors = 0;
    int extras = 0;
    logic [95:0] exp_q [$];
    bit   done = 1'b0;

    always #2 clk = ~clk;

    wire_msg_bridge #(.N_IRQ(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [95:0] act,
                       input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        #1;
        chk(reg_rdata == e, tag, {64'h0, reg_rdata}, {64'h0, e});
    endtask

    task automatic expect_msg(input logic [63:0] a, input logic [31:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic set_irq(input int n, input logic v);
        @(posedge clk); #1;
        irq_in[n] = v;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(posedge clk);
        repeat (12) @(posedge clk);
        chk(exp_q.size() == 0 && extras == 0, tag, 96'(exp_q.size()), 96'(0));
        extras = 0;
    endtask

    // monitor: compares each accepted message, and the hold rule while stalled
    logic        stall_prev = 1'b0;
    logic [95:0] held;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev)
                chk(msg_valid && {msg_addr, msg_data} == held, "R9 hold",
                    {msg_addr, msg_data}, held);
            stall_prev = msg_valid && !msg_ready;
            held = {msg_addr, msg_data};
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    extras++;
                    chk(1'b0, "R6/R7 unexpected message", {msg_addr, msg_data}, 96'h0);
                end else begin
                    logic [95:0] e;
                    e = exp_q.pop_front();
                    chk({msg_addr, msg_data} == e, "R3/R4/R5/R8 message",
                        {msg_addr, msg_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk(msg_valid == 1'b0, "R1 valid", {95'h0, msg_valid}, 96'h0);
        rd_chk(12'h010, 32'h0, "R1 doorbell");
        rd_chk(12'h054, 32'h0, "R1 doorbell");
        rd_chk(12'h10C, 32'h0, "R1 cfg");

        // R2: doorbells and configuration words
        wr(12'h010, SET0[31:0]); wr(12'h014, SET0[63:32]);
        wr(12'h018, CLR0[31:0]); wr(12'h01C, CLR0[63:32]);
        wr(12'h050, SET1[31:0]); wr(12'h054, SET1[63:32]);
        rd_chk(12'h018, CLR0[31:0], "R2 clear low");
        rd_chk(12'h054, SET1[63:32], "R2 edge set high");
        wr(12'h43C, 32'hFFFF_FFFF);
        rd_chk(12'h43C, 32'h0, "R2 index past last");
        wr(12'h10C, 32'h1100_0123);   // line 3: group 0, edge, payload 0x123
        wr(12'h114, 32'h0100_0055);   // line 5: group 0, level
        wr(12'h124, 32'h2100_0099);   // line 9: group 1, edge bit clear
        wr(12'h130, 32'h0000_0012);   // line 12: disabled
        wr(12'h138, 32'h4100_0014);   // line 14: group 2
        wr(12'h438, 32'h11AB_CDEF);   // line 206: group 0, edge
        rd_chk(12'h438, 32'h11AB_CDEF, "R2 last line");
        rd_chk(12'h114, 32'h0100_0055, "R2 cfg");

        // R3: edge mode, one message on rise, none on fall
        expect_msg(SET0, 32'h0000_0123);
        set_irq(3, 1'b1); repeat (5) @(posedge clk);
        set_irq(3, 1'b0);
        drain("R3 edge");

        // R4: level mode set then clear
        expect_msg(SET0, 32'h0000_0055);
        set_irq(5, 1'b1);
        drain("R4 level rise");
        expect_msg(CLR0, 32'h0000_0055);
        set_irq(5, 1'b0);
        drain("R4 level fall");

        // R5: edge-only group
        expect_msg(SET1, 32'h0000_0099);
        set_irq(9, 1'b1); repeat (5) @(posedge clk);
        set_irq(9, 1'b0);
        drain("R5 edge-only group");

        // R6: disabled line and unknown group
        set_irq(12, 1'b1); set_irq(14, 1'b1); repeat (5) @(posedge clk);
        set_irq(12, 1'b0); set_irq(14, 1'b0);
        drain("R6 silent lines");

        // R8 + R9: three lines at once under back-pressure
        @(posedge clk); #1 msg_ready = 1'b0;
        expect_msg(SET0, 32'h0000_0123);
        expect_msg(SET1, 32'h0000_0099);
        expect_msg(SET0, 32'h00AB_CDEF);
        @(posedge clk); #1 irq_in[206] = 1'b1; irq_in[9] = 1'b1; irq_in[3] = 1'b1;
        repeat (10) @(posedge clk);
        #1 msg_ready = 1'b1;
        drain("R8 ascending order");
        @(posedge clk); #1 irq_in[206] = 1'b0; irq_in[9] = 1'b0; irq_in[3] = 1'b0;
        drain("R8 falls silent");

        // R7: zero written to a line whose event waits behind a stalled message
        @(posedge clk); #1 msg_ready = 1'b0;
        expect_msg(SET0, 32'h0000_0123);
        @(posedge clk); #1 irq_in[206] = 1'b1; irq_in[3] = 1'b1;
        repeat (4) @(posedge clk);
        wr(12'h438, 32'h0);
        repeat (3) @(posedge clk);
        #1 msg_ready = 1'b1;
        drain("R7 pending discarded");
        rd_chk(12'h438, 32'h0, "R7 word cleared");
        set_irq(206, 1'b0); set_irq(206, 1'b1); set_irq(206, 1'b0);
        drain("R7 deconfigured line silent");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule